// File: doc/BRIEF.md
# Register-Fed Add/Subtract ALU

This block is the arithmetic stage of a small bus-based processor. It takes two 8-bit operands straight from the outputs of the A and B data registers, not from the shared data bus, and forms either their sum or their difference. A single subtract control picks between the two.

Subtraction reuses the adder. Each B bit passes through an XOR gate with the subtract line, and the same line feeds the carry input of the lowest adder stage, which together give the two's complement of B. The adder is a ripple chain of two nibble stages.

The result is always shown on a display output. It reaches the shared bus only while an output-enable is high. The block also returns a carry flag, which is the raw final carry-out, and a zero flag. The whole block is combinational.

Top module: `addsub_alu`

## Requirements
- R1: With `sub_i` = 0, `disp_o` equals (`a_i` + `b_i`) mod 256.
- R2: With `sub_i` = 1, `disp_o` equals (`a_i` − `b_i`) mod 256, in two's complement.
- R3: With `sub_i` = 0, `cy_o` is bit 8 of the 9-bit unsigned sum `a_i` + `b_i`.
- R4: With `sub_i` = 1, `cy_o` is 1 exactly when `a_i` ≥ `b_i` as unsigned values, meaning no borrow. For example, 5−5 gives 0 with carry 1, and 3−5 gives 0xFE with carry 0.
- R5: `zr_o` is 1 exactly when all 8 bits of the result are 0, in either mode.
- R6: `disp_o` shows the result whatever the value of `oe_i`.
- R7: `bus_vld_o` equals `oe_i`. `bus_o` equals the result while `oe_i` = 1 and is all zeros while `oe_i` = 0.
- R8: A carry out of bit 3 ripples into bit 4. For example, 0x0F + 0x01 gives 0x10, and 0x10 − 0x01 gives 0x0F with carry 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 8 | Operand from the A register |
| b_i | input | 8 | Operand from the B register |
| sub_i | input | 1 | 1 = subtract, 0 = add |
| oe_i | input | 1 | Enables driving the result onto the shared bus |
| disp_o | output | 8 | Result, always visible |
| bus_o | output | 8 | Bus-side result, zero while not driving |
| bus_vld_o | output | 1 | High while the bus is driven |
| cy_o | output | 1 | Carry-out of the high nibble stage |
| zr_o | output | 1 | High when the result is zero |

## Verification
No output passes through a register, so every result and flag belongs to the same cycle as the operands and controls that produce it. The bench changes the inputs on the falling clock edge and samples all outputs one nanosecond later, after the logic has settled and well before the next rising edge. The exhaustive sweeps cover every operand pair in both modes. During those sweeps the output-enable toggles with the operand bits, so the gating is exercised against both arithmetic results.

// File: rtl/addsub_alu_pkg.sv
package addsub_alu_pkg;
  parameter int unsigned DATA_W = 8;
  parameter int unsigned NIB_W  = 4;
  localparam int unsigned NIB_N = DATA_W / NIB_W;
endpackage

// File: rtl/alu_operand_cond.sv
module alu_operand_cond #(
  parameter int unsigned W = addsub_alu_pkg::DATA_W
) (
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] b_o
);
  for (genvar i = 0; i < W; i++) begin : g_xor
    assign b_o[i] = b_i[i] ^ sub_i;
  end
endmodule

// File: rtl/alu_nibble_add.sv
module alu_nibble_add #(
  parameter int unsigned W = addsub_alu_pkg::NIB_W
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         ci_i,
  output logic [W-1:0] s_o,
  output logic         co_o
);
  logic [W:0] c;
  assign c[0] = ci_i;
  for (genvar i = 0; i < W; i++) begin : g_fa
    assign s_o[i]  = a_i[i] ^ b_i[i] ^ c[i];
    assign c[i+1]  = (a_i[i] & b_i[i]) | (c[i] & (a_i[i] ^ b_i[i]));
  end
  assign co_o = c[W];
endmodule

// File: rtl/alu_ripple.sv
module alu_ripple #(
  parameter int unsigned DATA_W = addsub_alu_pkg::DATA_W,
  parameter int unsigned NIB_W  = addsub_alu_pkg::NIB_W,
  localparam int unsigned NIB_N = DATA_W / NIB_W
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              ci_i,
  output logic [DATA_W-1:0] s_o,
  output logic              co_o
);
  logic [NIB_N:0] c;
  assign c[0] = ci_i;
  for (genvar n = 0; n < NIB_N; n++) begin : g_stage
    alu_nibble_add #(.W(NIB_W)) u_nib (
      .a_i (a_i[n*NIB_W +: NIB_W]),
      .b_i (b_i[n*NIB_W +: NIB_W]),
      .ci_i(c[n]),
      .s_o (s_o[n*NIB_W +: NIB_W]),
      .co_o(c[n+1])
    );
  end
  assign co_o = c[NIB_N];
endmodule

// File: rtl/alu_flags.sv
module alu_flags #(
  parameter int unsigned W = addsub_alu_pkg::DATA_W
) (
  input  logic [W-1:0] sum_i,
  input  logic         co_i,
  output logic         cy_o,
  output logic         zr_o
);
  assign cy_o = co_i;
  assign zr_o = ~|sum_i;
endmodule

// File: rtl/alu_bus_gate.sv
module alu_bus_gate #(
  parameter int unsigned W = addsub_alu_pkg::DATA_W
) (
  input  logic [W-1:0] res_i,
  input  logic         oe_i,
  output logic [W-1:0] bus_o,
  output logic         bus_vld_o
);
  assign bus_o     = oe_i ? res_i : '0;
  assign bus_vld_o = oe_i;
endmodule

// File: rtl/addsub_alu.sv
module addsub_alu #(
  parameter int unsigned DATA_W = addsub_alu_pkg::DATA_W,
  parameter int unsigned NIB_W  = addsub_alu_pkg::NIB_W
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              sub_i,
  input  logic              oe_i,
  output logic [DATA_W-1:0] disp_o,
  output logic [DATA_W-1:0] bus_o,
  output logic              bus_vld_o,
  output logic              cy_o,
  output logic              zr_o
);
  logic [DATA_W-1:0] b_cond;
  logic [DATA_W-1:0] sum;
  logic              co;

  alu_operand_cond #(.W(DATA_W)) u_cond (
    .b_i  (b_i),
    .sub_i(sub_i),
    .b_o  (b_cond)
  );

  alu_ripple #(.DATA_W(DATA_W), .NIB_W(NIB_W)) u_add (
    .a_i (a_i),
    .b_i (b_cond),
    .ci_i(sub_i),
    .s_o (sum),
    .co_o(co)
  );

  alu_flags #(.W(DATA_W)) u_flags (
    .sum_i(sum),
    .co_i (co),
    .cy_o (cy_o),
    .zr_o (zr_o)
  );

  alu_bus_gate #(.W(DATA_W)) u_gate (
    .res_i    (sum),
    .oe_i     (oe_i),
    .bus_o    (bus_o),
    .bus_vld_o(bus_vld_o)
  );

  assign disp_o = sum;

  always_comb begin
    if (!$isunknown({a_i, b_i, sub_i, oe_i})) begin
      if (!sub_i) begin
        AST_ADD_SUM: assert ({cy_o, disp_o} == ({1'b0, a_i} + {1'b0, b_i})); // R1
      end
      if (sub_i) begin
        AST_SUB_DIFF: assert (disp_o == DATA_W'(a_i - b_i)); // R2
        AST_SUB_CARRY: assert (cy_o == (a_i >= b_i)); // R4
      end
      AST_ZERO_FLAG: assert (zr_o == (disp_o == '0)); // R5
      if (!oe_i) begin
        AST_BUS_IDLE: assert (bus_o == '0 && !bus_vld_o); // R7
      end
      if (oe_i) begin
        AST_BUS_DRIVE: assert (bus_o == disp_o && bus_vld_o); // R7
      end
    end
  end
endmodule

// File: tb/sim_addsub_alu.sv
`timescale 1ns/1ps
module sim_addsub_alu;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [7:0] a, b, disp, bus;
  logic       sub, oe, bus_vld, cy, zr;
  int n_chk = 0;
  int n_bad = 0;

  addsub_alu u0 (
    .a_i(a), .b_i(b), .sub_i(sub), .oe_i(oe),
    .disp_o(disp), .bus_o(bus), .bus_vld_o(bus_vld), .cy_o(cy), .zr_o(zr)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s a=%02h b=%02h sub=%0b oe=%0b act=%0h exp=%0h",
               req, a, b, sub, oe, act, exp);
    end
  endtask

  task automatic apply(input int av, input int bv, input bit s, input bit o);
    @(negedge clk);
    a = 8'(av); b = 8'(bv); sub = s; oe = o;
    #1;
  endtask

  // full check of all outputs against the requirements
  task automatic check_all();
    int r, c;
    if (!sub) begin
      r = (int'(a) + int'(b)) & 255;
      c = ((int'(a) + int'(b)) >> 8) & 1;
      chk("R1", disp, r);
      chk("R3", cy, c);
    end else begin
      r = (int'(a) - int'(b)) & 255;
      c = (a >= b) ? 1 : 0;
      chk("R2", disp, r);
      chk("R4", cy, c);
    end
    chk("R5", zr, (r == 0) ? 1 : 0);
    chk("R6", disp, r);
    chk("R7", bus_vld, oe);
    chk("R7", bus, oe ? r : 0);
  endtask

  task automatic t_idle_inputs();
    apply(0, 0, 0, 0);
    chk("R5", zr, 1);
    chk("R7", bus, 0);
    chk("R7", bus_vld, 0);
    check_all();
  endtask

  task automatic t_corners();
    apply(5, 5, 1, 1);     chk("R4", cy, 1); chk("R5", zr, 1); chk("R2", disp, 0);
    apply(3, 5, 1, 1);     chk("R2", disp, 8'hFE); chk("R4", cy, 0);
    apply(8'h0F, 1, 0, 1); chk("R8", disp, 8'h10); chk("R3", cy, 0);
    apply(8'h10, 1, 1, 1); chk("R8", disp, 8'h0F); chk("R8", cy, 1);
    apply(8'hFF, 1, 0, 1); chk("R3", cy, 1); chk("R5", zr, 1);
    apply(0, 8'hFF, 1, 0); chk("R2", disp, 1); chk("R4", cy, 0);
    apply(8'h80, 8'h80, 0, 0); chk("R3", cy, 1); chk("R5", zr, 1);
  endtask

  task automatic t_bus_gate();
    apply(8'h12, 8'h34, 0, 0);
    chk("R6", disp, 8'h46); chk("R7", bus, 0); chk("R7", bus_vld, 0);
    apply(8'h12, 8'h34, 0, 1);
    chk("R6", disp, 8'h46); chk("R7", bus, 8'h46); chk("R7", bus_vld, 1);
    apply(8'h12, 8'h34, 0, 0);
    chk("R7", bus, 0); chk("R6", disp, 8'h46);
  endtask

  task automatic t_sweep(input bit s);
    for (int i = 0; i < 256; i++) begin
      for (int j = 0; j < 256; j++) begin
        apply(i, j, s, bit'((i ^ j) & 1));
        check_all();
      end
    end
  endtask

  initial begin
    a = '0; b = '0; sub = 1'b0; oe = 1'b0;
    t_idle_inputs();
    t_corners();
    t_bus_gate();
    t_sweep(1'b0);
    t_sweep(1'b1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule